// File: doc/BRIEF.md
# Rate 2/3 (1,7) Run-Length-Limited Encoder

This block converts a stream of 2-bit parallel NRZ data into a serial (1,7) run-length-limited code for a disk write path. Each 2-bit data pair becomes three code bits. The result never places two 1s next to each other and never has more than seven 0s in a row. One pair of lookahead lets the block replace the ends of pairs that would clash with a 6-bit substitution word.

The block runs on the code-rate clock. The write clock arrives as a one-cycle strobe `wclk_en` on every third code cycle, which is half the NRZ bit rate. A write gate starts and stops each burst and clears all encoder state. An erase input forces a steady level onto the output without stopping the encoder. A bypass setting routes the NRZ LSB straight to the output for test patterns. An inversion setting complements the output in every mode.

Top module: `rll17_encoder`

## Requirements
- R1: Each pair maps to a triplet, with `nrz_in[1]` as the earlier data bit and code bits written first-out leftmost: 00→101, 01→100, 10→001, 11→010.
- R2: When the pair being encoded is 00 or 10 and the following pair is 00 or 01, the two pairs together emit 101000 (00,00), 100000 (00,01), 001000 (10,00) or 010000 (10,01). The second pair is then consumed and is not encoded on its own.
- R3: `wclk_en` pulses for one cycle every third code cycle, and each pulse captures `nrz_in`. Each triplet leaves `code_o` on three consecutive code cycles, and successive triplets follow one another with no gap.
- R4: After `wr_gate` rises, the first strobe edge (e0) captures pair D0. `code_o` carries 0 (before inversion) after edges e0 to e3, and the first code bit of D0 appears after edge e0+4.
- R5: While encoding, `code_o` (after removing inversion) never holds 1 on two successive cycles and never holds 0 on more than seven successive cycles.
- R6: While `wr_gate` is low, `code_o` is 0 (before inversion) one cycle later, and strobes and data are ignored. All encoder state is cleared, including a pending substitution tail, so the next burst starts fresh.
- R7: While `wr_gate` and `erase` are high, `code_o` is 0 (before inversion) one cycle later. The encoder keeps running, so after `erase` falls the code resumes at its normal position in the stream.
- R8: With `cfg_bypass` high, `wr_gate` high and `erase` low, `code_o` after each edge equals `nrz_in[0]` sampled at that edge (before inversion).
- R9: `cfg_invert` high complements `code_o` in every mode, one cycle after it is sampled.
- R10: `arst_n` low drives `code_o` to 0 at once, and the reset is released in step with `clk` after two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-rate clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| wr_gate | input | 1 | Write burst enable; low clears the encoder |
| wclk_en | input | 1 | Write-clock strobe, one cycle in three |
| nrz_in | input | 2 | NRZ data pair, bit 1 is the earlier bit |
| erase | input | 1 | Force a steady level for DC erase |
| cfg_bypass | input | 1 | Route `nrz_in[0]` straight to the output |
| cfg_invert | input | 1 | Complement the output |
| code_o | output | 1 | Serial code bit |

## Verification
Erase can overlap the encoder's own sequencing in the same cycle. It can cover the cycle in which a substitution head is loaded, or the cycle in which its 000 tail is shifted out. The bench opens an erase window across the middle of a stream. It checks that every bit in the window is forced to the inverted-zero level, and that the first bit after the window matches the reference at its original index. A write-gate drop is also placed on the edge right after a substitution head is loaded. The next burst must then start with the plain triplet of its first pair rather than a leftover 000 tail.

// File: rtl/rll17_pkg.sv
package rll17_pkg;

  localparam int unsigned SYM_W  = 2;
  localparam int unsigned CODE_W = 3;

  typedef logic [SYM_W-1:0]  sym_t;
  typedef logic [CODE_W-1:0] code_t;

  typedef enum logic [1:0] {
    LA_EMPTY  = 2'd0,
    LA_PRIMED = 2'd1,
    LA_TAIL   = 2'd2
  } la_state_e;

  function automatic code_t base_code(input sym_t s);
    code_t c;
    case (s)
      2'b00:   c = 3'b101;
      2'b01:   c = 3'b100;
      2'b10:   c = 3'b001;
      default: c = 3'b010;
    endcase
    return c;
  endfunction

  // true when cur ends in a 1 and nxt starts with a 1 under the base table
  function automatic logic sub_pair(input sym_t cur, input sym_t nxt);
    return (cur[0] == 1'b0) && (nxt[1] == 1'b0);
  endfunction

  function automatic code_t sub_head(input sym_t cur, input sym_t nxt);
    code_t c;
    if (cur[1]) c = nxt[0] ? 3'b010 : 3'b001;
    else        c = nxt[0] ? 3'b100 : 3'b101;
    return c;
  endfunction

endpackage

// File: rtl/rll17_rst_sync.sv
module rll17_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/rll17_lookahead.sv
module rll17_lookahead
  import rll17_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  take,
  input  sym_t  sym_in,
  output logic  load_o,
  output code_t word_o
);

  la_state_e st_q, st_d;
  sym_t      held_q, held_d;

  always_comb begin
    st_d   = st_q;
    held_d = held_q;
    load_o = 1'b0;
    word_o = '0;
    if (clr) begin
      st_d   = LA_EMPTY;
      held_d = '0;
    end else if (take) begin
      held_d = sym_in;
      case (st_q)
        LA_EMPTY: st_d = LA_PRIMED;
        LA_TAIL: begin
          load_o = 1'b1;
          word_o = '0;
          st_d   = LA_PRIMED;
        end
        default: begin
          load_o = 1'b1;
          if (sub_pair(held_q, sym_in)) begin
            word_o = sub_head(held_q, sym_in);
            st_d   = LA_TAIL;
          end else begin
            word_o = base_code(held_q);
            st_d   = LA_PRIMED;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LA_EMPTY;
      held_q <= '0;
    end else begin
      st_q   <= st_d;
      held_q <= held_d;
    end
  end

endmodule

// File: rtl/rll17_serializer.sv
module rll17_serializer #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] word,
  output logic         bit_o
);

  logic [W-1:0] sreg_q, sreg_d;

  always_comb begin
    if (clr)       sreg_d = '0;
    else if (load) sreg_d = word;
    else           sreg_d = {sreg_q[W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sreg_q <= '0;
    else        sreg_q <= sreg_d;
  end

  assign bit_o = sreg_q[W-1];

endmodule

// File: rtl/rll17_out_stage.sv
module rll17_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic erase,
  input  logic bypass,
  input  logic invert,
  input  logic enc_bit,
  input  logic raw_bit,
  output logic code_o
);

  logic sel_bit, code_d, code_q;

  always_comb begin
    sel_bit = bypass ? raw_bit : enc_bit;
    code_d  = invert ^ (gate & ~erase & sel_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= 1'b0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

endmodule

// File: rtl/rll17_encoder.sv
module rll17_encoder
  import rll17_pkg::*;
(
  input  logic             clk,
  input  logic             arst_n,
  input  logic             wr_gate,
  input  logic             wclk_en,
  input  logic [SYM_W-1:0] nrz_in,
  input  logic             erase,
  input  logic             cfg_bypass,
  input  logic             cfg_invert,
  output logic             code_o
);

  logic  rst_n_s;
  logic  clr;
  logic  load;
  code_t word;
  logic  enc_bit;

  assign clr = ~wr_gate;

  rll17_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n_s)
  );

  rll17_lookahead u_lookahead (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (clr),
    .take   (wclk_en),
    .sym_in (nrz_in),
    .load_o (load),
    .word_o (word)
  );

  rll17_serializer #(.W(CODE_W)) u_ser (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (clr),
    .load  (load),
    .word  (word),
    .bit_o (enc_bit)
  );

  rll17_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .gate    (wr_gate),
    .erase   (erase),
    .bypass  (cfg_bypass),
    .invert  (cfg_invert),
    .enc_bit (enc_bit),
    .raw_bit (nrz_in[0]),
    .code_o  (code_o)
  );

endmodule

// File: rtl/rll17_encoder_chk.sv
module rll17_encoder_chk #(
  parameter int unsigned MAX_ZEROS = 7
) (
  input logic clk,
  input logic rst_n,
  input logic wr_gate,
  input logic erase,
  input logic cfg_bypass,
  input logic cfg_invert,
  input logic nrz_lsb,
  input logic code_o
);

  logic       live_q;
  logic       mode_q;
  logic       inv_q;
  logic [3:0] zrun_q;
  logic       lvl;

  assign lvl = code_o ^ inv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      mode_q <= 1'b0;
      inv_q  <= 1'b0;
      zrun_q <= '0;
    end else begin
      live_q <= 1'b1;
      mode_q <= wr_gate & ~erase & ~cfg_bypass;
      inv_q  <= cfg_invert;
      if (live_q && mode_q && !lvl) zrun_q <= (zrun_q == 4'hF) ? zrun_q : zrun_q + 4'd1;
      else                          zrun_q <= '0;
    end
  end

  // R5: no two adjacent ones in encoded output
  assert_no_adjacent_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(live_q) && mode_q && $past(mode_q) && $stable(inv_q))
      |-> !(lvl && $past(lvl)));

  // R5: zero runs bounded
  assert_zero_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (zrun_q <= 4'(MAX_ZEROS)));

  // R6: gate low forces the idle level
  assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(!wr_gate)) |-> (code_o == $past(cfg_invert)));

  // R7: erase forces the idle level
  assert_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(wr_gate && erase)) |-> (code_o == $past(cfg_invert)));

  // R8 and R9: bypass passes the LSB, optionally complemented
  assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q && $past(wr_gate && !erase && cfg_bypass))
      |-> (code_o == ($past(nrz_lsb) ^ $past(cfg_invert))));

endmodule

bind rll17_encoder rll17_encoder_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .wr_gate    (wr_gate),
  .erase      (erase),
  .cfg_bypass (cfg_bypass),
  .cfg_invert (cfg_invert),
  .nrz_lsb    (nrz_in[0]),
  .code_o     (code_o)
);

// File: tb/rll17_encoder_bench.sv
module rll17_encoder_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       arst_n;
  logic       wr_gate;
  logic       wclk_en;
  logic [1:0] nrz_in;
  logic       erase;
  logic       cfg_bypass;
  logic       cfg_invert;
  logic       code_o;

  int  n_chk;
  int  n_bad;
  bit  done;

  logic [1:0] pairs [0:399];
  bit         refb  [0:1199];
  bit         obs   [0:1199];

  rll17_encoder u_rll17_encoder (
    .clk        (clk),
    .arst_n     (arst_n),
    .wr_gate    (wr_gate),
    .wclk_en    (wclk_en),
    .nrz_in     (nrz_in),
    .erase      (erase),
    .cfg_bypass (cfg_bypass),
    .cfg_invert (cfg_invert),
    .code_o     (code_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic act, input logic expv, input string tag);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: code_o=%b expected %b at %0t", tag, act, expv, $time);
    end
  endtask

  function automatic bit [2:0] ref_single(input bit [1:0] p);
    return (p == 2'd0) ? 3'd5 : (p == 2'd1) ? 3'd4 : (p == 2'd2) ? 3'd1 : 3'd2;
  endfunction

  function automatic bit [2:0] ref_double(input bit [3:0] pq);
    bit [2:0] h;
    case (pq)
      4'b0000: h = 3'd5;
      4'b0001: h = 3'd4;
      4'b1000: h = 3'd1;
      default: h = 3'd2;
    endcase
    return h;
  endfunction

  // greedy parse of the pair list into the expected code bit list
  task automatic build_ref(input int n);
    int i;
    int t;
    bit [2:0] w;
    i = 0;
    t = 0;
    while (i < n) begin
      if (i + 1 < n && (pairs[i] == 2'd0 || pairs[i] == 2'd2) &&
          (pairs[i+1] == 2'd0 || pairs[i+1] == 2'd1)) begin
        w = ref_double({pairs[i], pairs[i+1]});
        for (int b = 2; b >= 0; b--) begin refb[t] = w[b]; t++; end
        for (int b = 0; b < 3; b++) begin refb[t] = 1'b0; t++; end
        i += 2;
      end else begin
        w = ref_single(pairs[i]);
        for (int b = 2; b >= 0; b--) begin refb[t] = w[b]; t++; end
        i += 1;
      end
    end
  endtask

  task automatic run_stream(input int n, input int ncmp, input bit inv,
                            input int er_lo, input int er_hi, input int cut,
                            input string tag);
    bit prev_er;
    bit prev_cut;
    bit cut_now;
    int steps;
    build_ref(n);
    prev_er  = 1'b0;
    prev_cut = 1'b0;
    steps    = 3 * ncmp + 5;
    for (int k = 0; k < steps; k++) begin
      @(negedge clk);
      if (k > 0) begin
        int  m;
        bit  expv;
        m = k - 1;
        if (prev_cut) begin
          chk(code_o, inv, "R6 gate low");
        end else if (prev_er) begin
          chk(code_o, inv, "R7 erase");
        end else if (m < 4) begin
          chk(code_o, inv, "R4 latency");
        end else begin
          expv = refb[m-4] ^ inv;
          obs[m-4] = code_o ^ inv;
          chk(code_o, expv, tag);
        end
      end
      cut_now    = (cut >= 0) && (k >= cut);
      wr_gate    = ~cut_now;
      wclk_en    = (k % 3 == 0);
      if (k % 3 == 0) nrz_in = pairs[k/3];
      erase      = (k >= er_lo) && (k < er_hi);
      cfg_invert = inv;
      prev_er    = erase;
      prev_cut   = cut_now;
    end
    @(negedge clk);
    wr_gate = 1'b0;
    wclk_en = 1'b0;
    erase   = 1'b0;
  endtask

  // gate low with strobes and data toggling: R6 ignored stimulus
  task automatic idle_check(input int cycles, input bit inv);
    wr_gate    = 1'b0;
    cfg_invert = inv;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (k > 0) chk(code_o, inv, "R6 idle");
      wclk_en = 1'b1;
      nrz_in  = 2'(k);
    end
    @(negedge clk);
    chk(code_o, inv, "R6 idle");
    wclk_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int  ones_adj;
    int  zrun;
    int  zmax;
    bit  prevb;
    bit  lsb_q;
    n_chk = 0;
    n_bad = 0;
    done  = 1'b0;
    arst_n     = 1'b0;
    wr_gate    = 1'b0;
    wclk_en    = 1'b0;
    nrz_in     = 2'd0;
    erase      = 1'b0;
    cfg_bypass = 1'b0;
    cfg_invert = 1'b1;

    // R10: reset holds the output low regardless of inversion
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(code_o, 1'b0, "R10 in reset");
    end
    cfg_invert = 1'b0;
    @(negedge clk);
    arst_n = 1'b1;
    for (int k = 0; k < 4; k++) @(negedge clk);
    chk(code_o, 1'b0, "R10 after release");

    // R1 R2 R3: every sequence of four pairs, plus 11 padding
    for (int s = 0; s < 256; s++) begin
      for (int q = 0; q < 4; q++) pairs[q] = 2'(s >> (2 * (3 - q)));
      pairs[4] = 2'd3;
      pairs[5] = 2'd3;
      run_stream(6, 4, 1'b0, -1, -1, -1, "R1 R2 R3 sweep");
    end

    // R5 R9: long random stream, inverted output
    void'($urandom(32'h1f7));
    for (int q = 0; q < 300; q++) pairs[q] = 2'($urandom_range(3, 0));
    pairs[300] = 2'd3;
    pairs[301] = 2'd3;
    run_stream(302, 300, 1'b1, -1, -1, -1, "R5 R9 random");
    ones_adj = 0;
    zrun     = 0;
    zmax     = 0;
    prevb    = 1'b0;
    for (int j = 0; j < 900; j++) begin
      if (obs[j] && prevb) ones_adj++;
      if (!obs[j]) begin zrun++; if (zrun > zmax) zmax = zrun; end
      else zrun = 0;
      prevb = obs[j];
    end
    n_chk++;
    if (ones_adj != 0) begin
      n_bad++;
      $display("FAIL R5: adjacent ones count %0d expected 0", ones_adj);
    end
    n_chk++;
    if (zmax > 7) begin
      n_bad++;
      $display("FAIL R5: longest zero run %0d expected at most 7", zmax);
    end

    // R7: erase window over a substitution-rich stream, inverted
    for (int q = 0; q < 30; q++) pairs[q] = (q % 3 == 2) ? 2'd1 : 2'((q % 2) * 2);
    pairs[30] = 2'd3;
    pairs[31] = 2'd3;
    run_stream(32, 30, 1'b1, 10, 26, -1, "R7 resume");

    // R6: drop the gate right after a substitution head is loaded
    pairs[0] = 2'd0; pairs[1] = 2'd0; pairs[2] = 2'd1; pairs[3] = 2'd3;
    pairs[4] = 2'd3; pairs[5] = 2'd3;
    run_stream(6, 4, 1'b0, -1, -1, 4, "R6 cut");
    idle_check(6, 1'b0);
    pairs[0] = 2'd1; pairs[1] = 2'd3; pairs[2] = 2'd2; pairs[3] = 2'd0;
    pairs[4] = 2'd3; pairs[5] = 2'd3;
    run_stream(6, 4, 1'b0, -1, -1, -1, "R6 fresh start");
    idle_check(6, 1'b1);

    // R8 R9: bypass, with erase taking precedence on some cycles
    cfg_bypass = 1'b1;
    wr_gate    = 1'b1;
    for (int ph = 0; ph < 2; ph++) begin
      bit er_q;
      bit inv_q;
      er_q  = 1'b0;
      inv_q = 1'b0;
      lsb_q = 1'b0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (k > 0) begin
          if (er_q) chk(code_o, inv_q, "R7 erase in bypass");
          else      chk(code_o, lsb_q ^ inv_q, "R8 R9 bypass");
        end
        cfg_invert = ph[0];
        nrz_in     = 2'($urandom_range(3, 0));
        wclk_en    = (k % 3 == 0);
        erase      = (k % 7 == 3);
        er_q       = erase;
        inv_q      = cfg_invert;
        lsb_q      = nrz_in[0];
      end
    end
    @(negedge clk);
    erase      = 1'b0;
    wr_gate    = 1'b0;
    cfg_bypass = 1'b0;
    wclk_en    = 1'b0;
    @(negedge clk);
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule